// File: doc/BRIEF.md
# UART Register and Interrupt Unit

This block is the software-facing half of a simple byte UART. It sits on an APB bus as a slave and holds five registers: a data port, a status word, a control word, an interrupt status word and a baud divisor. It also holds a read-only block of twelve identification words. Behind the registers it keeps a one-byte transmit holding buffer and a one-byte receive holding buffer. Each buffer has a full flag and an overrun flag.

A separate serial engine does the bit-level shifting. It meets this block through two byte handshakes. On the transmit side the engine takes `tx_byte` when `tx_valid` and `tx_accept` are both high. On the receive side the engine delivers `rx_byte` when `rx_valid` and `rx_ready` are both high. The block derives four individual interrupt lines and one combined line. The two overrun interrupts are not latched. Each is the live product of an overrun flag and its enable.

Top module: `apb_uart_regs`

## Requirements
- R1: After reset, every register reads zero, both holding buffers are zero, and all five interrupt outputs, `tx_valid` and `rx_ready` are low.
- R2: The control word (offset 0x08) keeps only bits 6:0. Bit 0 enables TX, bit 1 enables RX, bit 2 enables the TX interrupt, bit 3 enables the RX interrupt, bit 4 enables the TX overrun interrupt, bit 5 enables the RX overrun interrupt, and bit 6 drives `hs_test`. The baud divisor (offset 0x10) keeps bits 19:0 and drives `baud_div`.
- R3: Writing the data port (offset 0x00) while TX is not full loads the byte onto `tx_byte` and sets status bit 0. `tx_valid` is status bit 0 ANDed with control bit 0. A handshake on the TX side clears status bit 0, and if control bit 2 is set it also sets interrupt status bit 0.
- R4: Writing the data port while status bit 0 is set, with no TX handshake in that cycle, sets status bit 2 (TX overrun). The new byte still replaces the held one.
- R5: `rx_ready` equals control bit 1. A handshake on the RX side loads the byte into the receive buffer and sets status bit 1. If control bit 3 is set, it also sets interrupt status bit 1. With RX disabled, an offered byte is never taken.
- R6: An RX handshake while status bit 1 is already set sets status bit 3 (RX overrun) and overwrites the buffer. This does not happen if the data port is being read in the same cycle.
- R7: Reading the data port returns the receive buffer in bits 7:0 and clears status bit 1. An RX handshake in that same cycle leaves status bit 1 set, and the new byte is held.
- R8: Writing status (offset 0x04) clears bit 2 or bit 3 wherever the written value has a 1. Bits 0 and 1 ignore writes.
- R9: Interrupt status (offset 0x0C) bits 0 and 1 are latched and write-one-to-clear. Bit 2 always equals status bit 2 AND control bit 4, and bit 3 always equals status bit 3 AND control bit 5. Writing 1 to bit 2 or bit 3 clears the matching status overrun flag.
- R10: `irq_tx`, `irq_rx`, `irq_txovr` and `irq_rxovr` follow interrupt status bits 0 to 3. `irq_any` is their OR.
- R11: The identification words are at 0xFD0 to 0xFFC. In address order they read 0x04, 0x00, 0x00, 0x00, 0x21, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to them are ignored.
- R12: Unmapped offsets read zero and ignore writes. `pready` is always high and `pslverr` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address within the block |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| tx_byte | output | 8 | Held transmit byte |
| tx_valid | output | 1 | Transmit byte offered to the serial engine |
| tx_accept | input | 1 | Serial engine takes the transmit byte |
| rx_byte | input | 8 | Received byte from the serial engine |
| rx_valid | input | 1 | Serial engine offers a received byte |
| rx_ready | output | 1 | Block takes received bytes |
| baud_div | output | DIV_W | Programmed baud divisor |
| hs_test | output | 1 | High-speed test mode bit |
| irq_tx | output | 1 | TX buffer drained interrupt |
| irq_rx | output | 1 | RX byte arrived interrupt |
| irq_txovr | output | 1 | TX overrun interrupt |
| irq_rxovr | output | 1 | RX overrun interrupt |
| irq_any | output | 1 | OR of all four interrupts |

## Verification
A wrong full or overrun flag shows up within one access. It is visible in the status read that follows, on `tx_valid` in the next cycle, and on the overrun interrupt lines as soon as the enable bit is set. A latched interrupt bit that fails to clear keeps `irq_any` high after the write-one-to-clear. A lost or duplicated receive byte appears as a wrong data-port read. The same-cycle collisions get their own directed cases, because an error there would otherwise stay hidden: a data read racing a receive handshake, and a data write racing a transmit handshake.

// File: rtl/apb_uart_regs.sv
module apb_uart_regs #(
  parameter int ADDR_W = 12,
  parameter int DIV_W  = 20
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  input  logic              tx_accept,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [DIV_W-1:0]  baud_div,
  output logic              hs_test,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_txovr,
  output logic              irq_rxovr,
  output logic              irq_any
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_DATA = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_STAT = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_CTRL = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_INT  = WORD_W'(3);
  localparam logic [WORD_W-1:0] W_BAUD = WORD_W'(4);
  localparam logic [WORD_W-1:0] W_ID0  = WORD_W'('hFD0 >> 2);
  localparam logic [WORD_W-1:0] W_IDN  = WORD_W'('hFFC >> 2);

  function automatic logic [7:0] id_value(input logic [3:0] idx);
    case (idx)
      4'd0:    id_value = 8'h04;
      4'd4:    id_value = 8'h21;
      4'd5:    id_value = 8'hB8;
      4'd6:    id_value = 8'h1B;
      4'd8:    id_value = 8'h0D;
      4'd9:    id_value = 8'hF0;
      4'd10:   id_value = 8'h05;
      4'd11:   id_value = 8'hB1;
      default: id_value = 8'h00;
    endcase
  endfunction

  logic [7:0]       tx_buf, rx_buf;
  logic             tx_full, rx_full, tx_ovr, rx_ovr;
  logic             int_tx, int_rx;
  logic [6:0]       ctrl;
  logic [DIV_W-1:0] baud;

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] id_off;
  logic acc, wr, rd;
  logic wr_data, wr_stat, wr_ctrl, wr_int, wr_baud, rd_data;
  logic tx_take, rx_take;
  logic txo_clr, rxo_clr;
  logic [3:0] int_vec;

  assign word    = paddr[ADDR_W-1:2];
  assign id_off  = word - W_ID0;
  assign acc     = psel & penable;
  assign wr      = acc & pwrite;
  assign rd      = acc & ~pwrite;
  assign wr_data = wr & (word == W_DATA);
  assign wr_stat = wr & (word == W_STAT);
  assign wr_ctrl = wr & (word == W_CTRL);
  assign wr_int  = wr & (word == W_INT);
  assign wr_baud = wr & (word == W_BAUD);
  assign rd_data = rd & (word == W_DATA);

  assign tx_valid = tx_full & ctrl[0];
  assign rx_ready = ctrl[1];
  assign tx_take  = tx_valid & tx_accept;
  assign rx_take  = rx_valid & rx_ready;

  assign txo_clr = (wr_stat | wr_int) & pwdata[2];
  assign rxo_clr = (wr_stat | wr_int) & pwdata[3];

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      tx_buf  <= '0;
      tx_full <= 1'b0;
      tx_ovr  <= 1'b0;
      int_tx  <= 1'b0;
    end else begin
      if (wr_data) tx_buf <= pwdata[7:0];
      tx_full <= (tx_full & ~tx_take) | wr_data;
      tx_ovr  <= (tx_ovr & ~txo_clr) | (wr_data & tx_full & ~tx_take);
      int_tx  <= (int_tx & ~(wr_int & pwdata[0])) | (tx_take & ctrl[2]);
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
      int_rx  <= 1'b0;
    end else begin
      if (rx_take) rx_buf <= rx_byte;
      rx_full <= (rx_full & ~rd_data) | rx_take;
      rx_ovr  <= (rx_ovr & ~rxo_clr) | (rx_take & rx_full & ~rd_data);
      int_rx  <= (int_rx & ~(wr_int & pwdata[1])) | (rx_take & ctrl[3]);
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl <= '0;
      baud <= '0;
    end else begin
      if (wr_ctrl) ctrl <= pwdata[6:0];
      if (wr_baud) baud <= pwdata[DIV_W-1:0];
    end
  end

  assign int_vec = {rx_ovr & ctrl[5], tx_ovr & ctrl[4], int_rx, int_tx};

  always_comb begin
    prdata = '0;
    if (rd) begin
      case (word)
        W_DATA:  prdata[7:0] = rx_buf;
        W_STAT:  prdata[3:0] = {rx_ovr, tx_ovr, rx_full, tx_full};
        W_CTRL:  prdata[6:0] = ctrl;
        W_INT:   prdata[3:0] = int_vec;
        W_BAUD:  prdata[DIV_W-1:0] = baud;
        default: if (word >= W_ID0 && word <= W_IDN) prdata[7:0] = id_value(id_off[3:0]);
      endcase
    end
  end

  assign pready    = 1'b1;
  assign pslverr   = 1'b0;
  assign tx_byte   = tx_buf;
  assign baud_div  = baud;
  assign hs_test   = ctrl[6];
  assign irq_tx    = int_vec[0];
  assign irq_rx    = int_vec[1];
  assign irq_txovr = int_vec[2];
  assign irq_rxovr = int_vec[3];
  assign irq_any   = |int_vec;
endmodule

// File: rtl/apb_uart_regs_chk.sv
module apb_uart_regs_chk #(
  parameter int ADDR_W = 12
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic              tx_valid,
  input logic              tx_accept,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_full,
  input logic              rx_full,
  input logic              tx_ovr,
  input logic              rx_ovr,
  input logic              irq_tx,
  input logic              irq_any
);
  logic acc_w, acc_r, at_data, at_stat;
  assign acc_w   = psel & penable & pwrite;
  assign acc_r   = psel & penable & ~pwrite;
  assign at_data = paddr[ADDR_W-1:2] == '0;
  assign at_stat = paddr[ADDR_W-1:2] == (ADDR_W-2)'(1);

  // R3
  tx_load_chk: assert property (@(posedge pclk) disable iff (!presetn)
    acc_w && at_data && !tx_full |=> tx_full);

  // R4
  tx_overrun_chk: assert property (@(posedge pclk) disable iff (!presetn)
    acc_w && at_data && tx_full && !(tx_valid && tx_accept) |=> tx_ovr);

  // R5
  rx_load_chk: assert property (@(posedge pclk) disable iff (!presetn)
    rx_valid && rx_ready |=> rx_full);

  // R6
  rx_overrun_chk: assert property (@(posedge pclk) disable iff (!presetn)
    rx_valid && rx_ready && rx_full && !(acc_r && at_data) |=> rx_ovr);

  // R7
  rx_drain_chk: assert property (@(posedge pclk) disable iff (!presetn)
    acc_r && at_data && !(rx_valid && rx_ready) |=> !rx_full);

  // R8
  stat_w1c_chk: assert property (@(posedge pclk) disable iff (!presetn)
    acc_w && at_stat && pwdata[2] |=> !tx_ovr);

  // R10
  irq_any_chk: assert property (@(posedge pclk) disable iff (!presetn)
    irq_tx |-> irq_any);
endmodule

bind apb_uart_regs apb_uart_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
  .tx_valid(tx_valid), .tx_accept(tx_accept),
  .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_full(tx_full), .rx_full(rx_full), .tx_ovr(tx_ovr), .rx_ovr(rx_ovr),
  .irq_tx(irq_tx), .irq_any(irq_any)
);

// File: tb/tb_apb_uart_regs.sv
module tb_apb_uart_regs;
  logic        clk = 1'b0;
  logic        rstn = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  tx_byte;
  logic        tx_valid, tx_accept = 0;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 0, rx_ready;
  logic [19:0] baud_div;
  logic        hs_test, irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  apb_uart_regs dut (
    .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_accept(tx_accept),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .baud_div(baud_div), .hs_test(hs_test), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_txovr(irq_txovr), .irq_rxovr(irq_rxovr), .irq_any(irq_any)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic take_tx();
    @(negedge clk); tx_accept = 1;
    @(negedge clk); tx_accept = 0;
  endtask

  task automatic t_reset();
    rd_chk("R1 status", 12'h004, 0);
    rd_chk("R1 ctrl", 12'h008, 0);
    rd_chk("R1 intstat", 12'h00C, 0);
    rd_chk("R1 baud", 12'h010, 0);
    rd_chk("R1 data", 12'h000, 0);
    check("R1 outputs", {irq_any, irq_tx, irq_rx, irq_txovr, irq_rxovr, tx_valid, rx_ready, tx_byte}, 0);
    check("R12 pready/pslverr", {pready, pslverr}, 2'b10);
  endtask

  task automatic t_config();
    wr(12'h008, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl width", 12'h008, 32'h7F);
    check("R2 hs_test", hs_test, 1);
    wr(12'h010, 32'hFFFF_FFFF);
    rd_chk("R2 baud width", 12'h010, 32'hFFFFF);
    check("R2 baud_div", baud_div, 20'hFFFFF);
    wr(12'h010, 32'h0_0123);
    check("R2 baud_div value", baud_div, 20'h00123);
    wr(12'h008, 0);
    check("R2 hs_test off", hs_test, 0);
  endtask

  task automatic t_tx();
    wr(12'h008, 32'h05);
    wr(12'h000, 32'hA5);
    rd_chk("R3 tx full", 12'h004, 32'h1);
    check("R3 tx_valid/byte", {tx_valid, tx_byte}, {1'b1, 8'hA5});
    wr(12'h000, 32'h3C);
    rd_chk("R4 tx overrun", 12'h004, 32'h5);
    check("R4 byte replaced", tx_byte, 8'h3C);
    check("R9 txo masked", {irq_txovr, irq_any}, 0);
    wr(12'h008, 32'h15);
    rd_chk("R9 txo live", 12'h00C, 32'h4);
    check("R10 irq_txovr", {irq_txovr, irq_any}, 2'b11);
    take_tx();
    rd_chk("R3 drained", 12'h004, 32'h4);
    rd_chk("R3 tx int", 12'h00C, 32'h5);
    check("R10 irq_tx", irq_tx, 1);
    check("R3 tx_valid low", tx_valid, 0);
    wr(12'h00C, 32'h4);
    rd_chk("R9 int w1c clears status", 12'h004, 32'h0);
    rd_chk("R9 int after txo clear", 12'h00C, 32'h1);
    wr(12'h00C, 32'h1);
    check("R9 tx int cleared", {irq_tx, irq_any}, 0);
    wr(12'h008, 32'h04);
    wr(12'h000, 32'h77);
    check("R3 tx disabled no valid", tx_valid, 0);
    take_tx();
    rd_chk("R3 held while disabled", 12'h004, 32'h1);
    wr(12'h008, 32'h01);
    take_tx();
    rd_chk("R3 drained no int", 12'h00C, 32'h0);
  endtask

  task automatic t_rx();
    wr(12'h008, 32'h0A);
    check("R5 rx_ready", rx_ready, 1);
    push_rx(8'h11);
    rd_chk("R5 rx full", 12'h004, 32'h2);
    rd_chk("R5 rx int", 12'h00C, 32'h2);
    check("R10 irq_rx", {irq_rx, irq_any}, 2'b11);
    push_rx(8'h22);
    rd_chk("R6 rx overrun", 12'h004, 32'hA);
    check("R9 rxo masked", irq_rxovr, 0);
    wr(12'h008, 32'h2A);
    rd_chk("R9 rxo live", 12'h00C, 32'hA);
    check("R10 irq_rxovr", irq_rxovr, 1);
    wr(12'h004, 32'h3);
    rd_chk("R8 ro bits ignore", 12'h004, 32'hA);
    wr(12'h004, 32'h8);
    rd_chk("R8 w1c rx overrun", 12'h004, 32'h2);
    check("R9 rxo follows", irq_rxovr, 0);
    rd_chk("R7 data overwritten", 12'h000, 32'h22);
    rd_chk("R7 rx full cleared", 12'h004, 32'h0);
    wr(12'h00C, 32'h2);
    check("R9 rx int w1c", irq_any, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(12'h008, 32'h02);
    push_rx(8'h33);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = 12'h000;
    @(negedge clk); penable = 1; rx_valid = 1; rx_byte = 8'h44; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0; rx_valid = 0;
    check("R7 collide returns old", d, 32'h33);
    rd_chk("R6 collide no overrun", 12'h004, 32'h2);
    rd_chk("R7 collide new byte", 12'h000, 32'h44);
    wr(12'h008, 32'h00);
    check("R5 rx_ready off", rx_ready, 0);
    push_rx(8'h55);
    rd_chk("R5 disabled ignored", 12'h004, 32'h0);
    rd_chk("R5 buffer kept", 12'h000, 32'h44);
  endtask

  task automatic t_id();
    logic [7:0] exp_id [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h21, 8'hB8,
                                8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 12; i++) rd_chk("R11 id word", 12'hFD0 + 12'(i * 4), {24'h0, exp_id[i]});
    wr(12'hFD0, 32'hFF);
    rd_chk("R11 id write ignored", 12'hFD0, 32'h04);
  endtask

  task automatic t_unmapped();
    wr(12'h008, 32'h03);
    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h800, 32'hFFFF_FFFF);
    rd_chk("R12 unmapped 0x14", 12'h014, 0);
    rd_chk("R12 unmapped 0x800", 12'h800, 0);
    rd_chk("R12 ctrl untouched", 12'h008, 32'h03);
    rd_chk("R12 status untouched", 12'h004, 32'h0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL R12 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstn = 1;
    t_reset();
    t_config();
    t_tx();
    t_rx();
    t_collide();
    t_id();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule